// File: doc/BRIEF.md
# Prescaled Reload Timer

A down-counting timer driven through a programmable clock divider. When started, the counter takes a 16-bit reload value, supplied as a high byte and a low byte. It then steps down by one on every divider tick. When a tick arrives while the counter already holds zero, an underflow occurs. The underflow raises an interrupt request flag, which stays set until the host clears it. After an underflow the timer either stops or, when auto-reload is enabled, takes the reload value again and keeps counting.

The host starts and halts the timer with single-cycle command strobes. A halt strobe overrides any start arriving in the same cycle. When automatic start is enabled, a single-cycle protocol event from a neighbouring engine also starts the timer. The live count is presented as two bytes, alongside a running flag and the interrupt flag.

Top module: `tick_reload_timer`

## Requirements
- R1: After reset, running is 0, the count reads 0 (count_hi = 0, count_lo = 0) and irq_flag is 0.
- R2: With divider value P, the divider produces one tick every 2P+1 clock cycles. The first tick comes 2P+1 cycles after the edge that sampled the start. Each tick lowers a nonzero count by exactly one.
- R3: A start_now pulse with stop_now low loads the count from {reload_hi, reload_lo}, sets running and restarts the divider. This also applies while the timer is already running.
- R4: A stop_now pulse clears running. While the timer is stopped, the count holds its value.
- R5: When stop_now is high in the same cycle as start_now or an automatic start, the stop wins. Running stays 0 and the count is not reloaded.
- R6: When auto_start_en is 1, a trigger_evt pulse starts the timer exactly as start_now does. When auto_start_en is 0, trigger_evt has no effect on running or on the count.
- R7: A tick that arrives while the count is 0 is an underflow, and it sets irq_flag. With auto_reload_en at 0, the underflow also clears running, and the count stays at 0.
- R8: With auto_reload_en at 1, an underflow loads the count from the reload value, and running stays 1.
- R9: irq_flag stays at 1 until an irq_clr pulse clears it. When an underflow and irq_clr fall in the same cycle, the flag ends up set.
- R10: count_hi carries count bits 15..8 and count_lo carries bits 7..0. reload_hi and reload_lo supply the same bit positions of the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_now | input | 1 | Start strobe from host |
| stop_now | input | 1 | Stop strobe from host; overrides starts |
| auto_start_en | input | 1 | Lets trigger_evt start the timer |
| trigger_evt | input | 1 | Protocol event pulse |
| auto_reload_en | input | 1 | Reload and continue on underflow |
| presc_val | input | 12 | Divider value P; tick period 2P+1 cycles |
| reload_hi | input | 8 | Reload value, upper byte |
| reload_lo | input | 8 | Reload value, lower byte |
| irq_clr | input | 1 | Clears the interrupt flag |
| count_hi | output | 8 | Live count, upper byte |
| count_lo | output | 8 | Live count, lower byte |
| running | output | 1 | Timer is counting |
| irq_flag | output | 1 | Underflow interrupt request |

## Verification
The hardest situation to reach from the ports is an underflow that lands in the same cycle as a host action, either an interrupt clear or a halt strobe. Normally the underflow edge lies hundreds of cycles after the start. The bench uses divider 0 and reload 0 so that the underflow falls on the very next edge after the start. It raises irq_clr in that cycle and expects the flag to remain set. The main sweep walks divider values 0 to 3 across several reload values, one of them above 255, and predicts the count, running flag and interrupt on every cycle from tick arithmetic.

// File: rtl/tick_timer_pkg.sv
// Shared constants and types for the prescaled reload timer.
// Assumes a byte-wide register view of multi-byte values.
package tick_timer_pkg;
    localparam int BYTE_W = 8;

    // Decision of the run controller for one cycle.
    typedef struct packed {
        logic load;   // take the reload value and (re)start
        logic halt;   // drop the running flag
    } run_ctl_t;
endpackage

// File: rtl/tmr_prescaler.sv
// Clock divider: while running, emits a one-cycle tick every 2P+1 cycles.
// Assumes presc_i is stable while the timer runs; clr_i restarts the phase.
module tmr_prescaler #(
    parameter int PRESC_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  logic               clr_i,
    input  logic [PRESC_W-1:0] presc_i,
    output logic               tick_o
);
    localparam int PC_W = PRESC_W + 1;

    logic [PC_W-1:0] pcnt_q;
    logic [PC_W-1:0] limit;

    // Terminal phase is 2P, giving a period of 2P+1 cycles.
    always_comb limit = {presc_i, 1'b0};

    // Tick when the phase reaches its limit while the timer runs.
    always_comb tick_o = run_i && (pcnt_q == limit);

    // Phase counter: cleared on start/stop, wraps after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            pcnt_q <= '0;
        end else if (run_i) begin
            pcnt_q <= tick_o ? '0 : pcnt_q + 1'b1;
        end
    end

    // R2
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !clr_i && $stable(presc_i) && pcnt_q <= limit) |=> (pcnt_q <= limit));
endmodule

// File: rtl/tmr_run_ctrl.sv
// Run controller: resolves start/stop/auto-start/underflow into the running
// flag. Assumes all strobes are single-cycle and synchronous to clk.
module tmr_run_ctrl
    import tick_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_now,
    input  logic     stop_now,
    input  logic     auto_start_en,
    input  logic     trigger_evt,
    input  logic     end_run_i,
    output run_ctl_t ctl_o,
    output logic     run_o
);
    logic go;
    logic run_q;

    // Merge manual and automatic start requests; stop overrides both.
    always_comb begin
        go         = start_now || (auto_start_en && trigger_evt);
        ctl_o.load = go && !stop_now;
        ctl_o.halt = stop_now || (end_run_i && !ctl_o.load);
    end

    // Running flag update.
    always_ff @(posedge clk) begin
        if (!rst_n)          run_q <= 1'b0;
        else if (ctl_o.load) run_q <= 1'b1;
        else if (ctl_o.halt) run_q <= 1'b0;
    end

    always_comb run_o = run_q;

    // R5
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_now |=> !run_q);
    // R3
    start_runs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_now && !stop_now) |=> run_q);
    // R6
    auto_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_start_en && trigger_evt && !stop_now) |=> run_q);
endmodule

// File: rtl/tmr_down_counter.sv
// Down counter with reload: loads on start, decrements per tick and reports
// underflow when a tick finds it at zero. Assumes tick_i is already gated
// by run and stop.
module tmr_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             auto_reload_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             underflow_o
);
    logic [CNT_W-1:0] cnt_q;

    // Underflow is a tick that finds the counter empty.
    always_comb underflow_o = tick_i && (cnt_q == '0);

    // Count register: load, decrement, reload or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= reload_i;
        end else if (underflow_o) begin
            if (auto_reload_i) cnt_q <= reload_i;
        end else if (tick_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb cnt_o = cnt_q;

    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !load_i) |=> $stable(cnt_q));
    // R2
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/tmr_irq_flag.sv
// Interrupt request flag: set by underflow, cleared by host; set wins.
// Assumes irq_clr_i is a host strobe.
module tmr_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic irq_clr_i,
    output logic irq_o
);
    logic irq_q;

    // Sticky flag with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq_q <= 1'b0;
        else if (set_i)     irq_q <= 1'b1;
        else if (irq_clr_i) irq_q <= 1'b0;
    end

    always_comb irq_o = irq_q;

    // R9
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> irq_q);
    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !irq_clr_i) |=> irq_q);
endmodule

// File: rtl/tick_reload_timer.sv
// Top of the prescaled reload timer: divider, run control, down counter and
// interrupt flag. Assumes host strobes are single-cycle and that reload and
// divider values are stable while they matter.
module tick_reload_timer
    import tick_timer_pkg::*;
#(
    parameter int PRESC_W = 12,
    parameter int CNT_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_now,
    input  logic                    stop_now,
    input  logic                    auto_start_en,
    input  logic                    trigger_evt,
    input  logic                    auto_reload_en,
    input  logic [PRESC_W-1:0]      presc_val,
    input  logic [CNT_W-BYTE_W-1:0] reload_hi,
    input  logic [BYTE_W-1:0]       reload_lo,
    input  logic                    irq_clr,
    output logic [CNT_W-BYTE_W-1:0] count_hi,
    output logic [BYTE_W-1:0]       count_lo,
    output logic                    running,
    output logic                    irq_flag
);
    localparam int HI_W = CNT_W - BYTE_W;

    run_ctl_t         ctl;
    logic             run;
    logic             raw_tick;
    logic             tick;
    logic             underflow;
    logic             end_run;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;

    // Assemble reload value and gate ticks by a same-cycle stop.
    always_comb begin
        reload  = {reload_hi, reload_lo};
        tick    = raw_tick && !stop_now;
        end_run = underflow && !auto_reload_en;
    end

    tmr_run_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_now     (start_now),
        .stop_now      (stop_now),
        .auto_start_en (auto_start_en),
        .trigger_evt   (trigger_evt),
        .end_run_i     (end_run),
        .ctl_o         (ctl),
        .run_o         (run)
    );

    tmr_prescaler #(.PRESC_W(PRESC_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run),
        .clr_i   (ctl.load || stop_now),
        .presc_i (presc_val),
        .tick_o  (raw_tick)
    );

    tmr_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (ctl.load),
        .run_i         (run),
        .tick_i        (tick),
        .auto_reload_i (auto_reload_en),
        .reload_i      (reload),
        .cnt_o         (cnt),
        .underflow_o   (underflow)
    );

    tmr_irq_flag u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (underflow),
        .irq_clr_i (irq_clr),
        .irq_o     (irq_flag)
    );

    // Byte split of the live count.
    always_comb begin
        count_hi = cnt[CNT_W-1 -: HI_W];
        count_lo = cnt[BYTE_W-1:0];
        running  = run;
    end

    // R7
    underflow_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !auto_reload_en && !start_now) |=> (!running && cnt == '0));
    // R8
    reload_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && auto_reload_en && !stop_now) |=> (running && cnt == $past(reload)));
endmodule

// File: tb/tick_reload_timer_test.sv
module tick_reload_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_now = 1'b0, stop_now = 1'b0;
    logic        auto_start_en = 1'b0, trigger_evt = 1'b0, auto_reload_en = 1'b0;
    logic [11:0] presc_val = '0;
    logic [7:0]  reload_hi = '0, reload_lo = '0;
    logic        irq_clr = 1'b0;
    logic [7:0]  count_hi, count_lo;
    logic        running, irq_flag;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tick_reload_timer uut (
        .clk(clk), .rst_n(rst_n), .start_now(start_now), .stop_now(stop_now),
        .auto_start_en(auto_start_en), .trigger_evt(trigger_evt),
        .auto_reload_en(auto_reload_en), .presc_val(presc_val),
        .reload_hi(reload_hi), .reload_lo(reload_lo), .irq_clr(irq_clr),
        .count_hi(count_hi), .count_lo(count_lo), .running(running), .irq_flag(irq_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int cnt_now();
        return {count_hi, count_lo};
    endfunction

    // Pulse one strobe for one edge; returns at the negedge after that edge.
    task automatic pulse_start();
        @(negedge clk); start_now = 1'b1;
        @(negedge clk); start_now = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    // Sweep one configuration; predict every cycle from tick arithmetic.
    task automatic sweep(input int p, input int r, input bit arl, input int cyc);
        presc_val = 12'(p);
        {reload_hi, reload_lo} = 16'(r);
        auto_reload_en = arl;
        clear_irq();
        pulse_start();
        for (int c = 0; c <= cyc; c++) begin
            int n, ec, er, ei;
            n = c / (2*p + 1);
            if (arl) begin
                ec = r - (n % (r + 1)); er = 1;
            end else begin
                ec = (n <= r) ? r - n : 0; er = (n <= r) ? 1 : 0;
            end
            ei = (n >= r + 1) ? 1 : 0;
            chk(arl ? "R8 count" : "R2/R10 count", cnt_now(), ec);
            chk(arl ? "R8 running" : "R7 running", int'(running), er);
            chk("R7 irq", int'(irq_flag), ei);
            @(negedge clk);
        end
        @(negedge clk); stop_now = 1'b1;
        @(negedge clk); stop_now = 1'b0;
    endtask

    initial begin
        #1_500_000;
        fails++; checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 running", int'(running), 0);
        chk("R1 count", cnt_now(), 0);
        chk("R1 irq", int'(irq_flag), 0);

        // R2 R7 R10: divider/reload sweep
        for (int p = 0; p < 4; p++) begin
            sweep(p, 0, 1'b0, 2*(2*p+1) + 2);
            sweep(p, 1, 1'b0, 3*(2*p+1) + 2);
            sweep(p, 3, 1'b0, 5*(2*p+1) + 2);
            sweep(p, 259, 1'b0, 261*(2*p+1) + 2);
        end
        // R8 auto-reload
        sweep(1, 2, 1'b1, 40);
        sweep(0, 5, 1'b1, 30);
        auto_reload_en = 1'b0;

        // R4 stop holds count
        presc_val = 12'd1; {reload_hi, reload_lo} = 16'd10;
        pulse_start();
        repeat (7) @(negedge clk);
        stop_now = 1'b1;
        @(negedge clk); stop_now = 1'b0;
        chk("R4 running", int'(running), 0);
        chk("R4 count", cnt_now(), 8);
        repeat (20) @(negedge clk);
        chk("R4 held", cnt_now(), 8);

        // R5 stop beats start and trigger
        start_now = 1'b1; stop_now = 1'b1;
        @(negedge clk); start_now = 1'b0; stop_now = 1'b0;
        chk("R5 running", int'(running), 0);
        chk("R5 count", cnt_now(), 8);
        auto_start_en = 1'b1; trigger_evt = 1'b1; stop_now = 1'b1;
        @(negedge clk); trigger_evt = 1'b0; stop_now = 1'b0;
        chk("R5 trig running", int'(running), 0);
        chk("R5 trig count", cnt_now(), 8);

        // R6 trigger ignored when disabled, honoured when enabled
        auto_start_en = 1'b0; trigger_evt = 1'b1;
        @(negedge clk); trigger_evt = 1'b0;
        chk("R6 ignored running", int'(running), 0);
        chk("R6 ignored count", cnt_now(), 8);
        auto_start_en = 1'b1; trigger_evt = 1'b1;
        @(negedge clk); trigger_evt = 1'b0; auto_start_en = 1'b0;
        chk("R6 started running", int'(running), 1);
        chk("R6 started count", cnt_now(), 10);
        @(negedge clk); stop_now = 1'b1;
        @(negedge clk); stop_now = 1'b0;

        // R3 restart while running reloads and restarts divider
        pulse_start();
        repeat (4) @(negedge clk);
        chk("R3 mid count", cnt_now(), 9);
        start_now = 1'b1;
        @(negedge clk); start_now = 1'b0;
        chk("R3 reload", cnt_now(), 10);
        repeat (2) @(negedge clk);
        chk("R3 phase", cnt_now(), 10);
        @(negedge clk);
        chk("R3 first tick", cnt_now(), 9);
        @(negedge clk); stop_now = 1'b1;
        @(negedge clk); stop_now = 1'b0;

        // R9 set beats clear in the underflow cycle; flag sticky until clear
        presc_val = 12'd0; {reload_hi, reload_lo} = 16'd0;
        clear_irq();
        pulse_start();
        irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        chk("R9 set wins", int'(irq_flag), 1);
        chk("R7 stopped", int'(running), 0);
        hold = 0;
        repeat (10) begin
            @(negedge clk);
            if (irq_flag) hold++;
        end
        chk("R9 sticky", hold, 10);
        clear_irq();
        chk("R9 cleared", int'(irq_flag), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule